// File: doc/BRIEF.md
# Scratchpad Address and Transfer-Status Unit

This unit sits beside the command decoder of a serial-bus memory device. It holds the target address of an eight-byte scratchpad transfer, and it produces the read-only ending-offset and status byte that the bus master reads back to confirm that a write arrived intact. The address comes in as a low byte and a high byte. The low byte is always snapped down to an eight-byte boundary, because the scratchpad only ever takes whole eight-byte blocks.

During a scratchpad write, each received data bit is offered on a valid/ready stream. The unit accepts bits only while a write is open (`bit_ready` high). When `bit_ready` is low, the bits are dropped and nothing counts them; the sender must not wait on `bit_ready` outside a write. The unit keeps a modulo-eight count of the accepted bits. A write ends on an end strobe or on a bus reset. If it ends on a whole byte, the partial flag is cleared. If it ends on a broken byte, the flag is set. A power loss marks the scratchpad invalid through the same flag. A copy-complete pulse from the copy sequencer sets the authorization flag, and the start of the next write clears it.

Top module: `scratch_addr_status`

## Requirements
- R1: After reset `target_addr` is 0, `bit_ready` is 0, and `status_byte` is 8'h7F: authorization 0, partial 1, all fixed bits 1.
- R2: A cycle with `addr_load` high loads `target_addr` from the next clock edge. The value is `{addr_hi, addr_lo}` with bits [2:0] forced to zero.
- R3: Bits 0, 1, 2, 3, 4 and 6 of `status_byte` always read 1. Bit 5 is the partial flag and bit 7 is the authorization flag.
- R4: `bit_ready` is high from the edge after `wr_start` until the edge that closes the write. Bits offered while it is low, and end or bus-reset strobes while no write is open, change nothing.
- R5: Closing a write after a multiple of eight accepted bits clears the partial flag. Zero bits counts as a multiple of eight.
- R6: Closing a write after a number of accepted bits that is not a multiple of eight sets the partial flag.
- R7: `bus_reset` closes an open write exactly as `wr_end` does.
- R8: `power_loss` sets the partial flag at the next edge. It wins over a write closing in the same cycle.
- R9: `copy_done` sets the authorization flag. `wr_start` clears it, and wins when both are high in the same cycle.
- R10: A bit accepted in the same cycle as the closing strobe is counted.
- R11: `wr_start` while a write is open restarts the bit count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load the target address from the two address bytes |
| addr_lo | input | 8 | Low address byte; bits [2:0] are discarded |
| addr_hi | input | 8 | High address byte |
| wr_start | input | 1 | Open a scratchpad write |
| bit_valid | input | 1 | A received data bit is offered |
| bit_ready | output | 1 | A write is open and the offered bit is taken |
| wr_end | input | 1 | Close the open write |
| bus_reset | input | 1 | Bus reset seen; closes the open write |
| power_loss | input | 1 | Scratchpad contents lost |
| copy_done | input | 1 | Copy sequencer finished an authorized copy |
| target_addr | output | 16 | Block-aligned target address |
| status_byte | output | 8 | Authorization, partial flag and fixed ending offset |

## Verification
Three pairs of events can meet in one cycle. A data bit can arrive with the closing strobe, a power loss can coincide with a clean close, and a copy-complete pulse can land on the start of a new write. The bench drives each pair together on a single negative clock edge. It then reads the status byte one cycle later and compares it against the priorities in R10, R8 and R9. Each collision is set up so that the two possible orders would leave different flag values.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam int BYTE_W   = 8;
  localparam int PF_POS   = 5;
  localparam int AUTH_POS = 7;
  localparam logic [BYTE_W-1:0] FIXED_ONES = 8'h5F;

  function automatic logic [BYTE_W-1:0] pack_status(input logic auth, input logic pf);
    logic [BYTE_W-1:0] s;
    s = FIXED_ONES;
    s[PF_POS] = pf;
    s[AUTH_POS] = auth;
    return s;
  endfunction
endpackage

// File: rtl/sas_addr_reg.sv
module sas_addr_reg #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [7:0]        lo_in,
  input  logic [ADDR_W-9:0] hi_in,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [7:0] ALIGN_MASK = ~8'((1 << OFF_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= {hi_in, lo_in & ALIGN_MASK};
  end

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr[ADDR_W-1:8] == $past(hi_in)) && (addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/sas_bit_counter.sv
module sas_bit_counter #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_fire,
  input  logic term,
  output logic active,
  output logic close_evt,
  output logic close_partial
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_with_bit;

  always_comb begin
    cnt_with_bit  = cnt + CNT_W'(bit_fire);
    close_evt     = active && term && !start;
    close_partial = cnt_with_bit != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (close_evt) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (bit_fire) begin
      cnt    <= cnt_with_bit;
    end
  end

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && (cnt == '0));
  assert_stays_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !term) |=> active);
  assert_idle_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !active);
endmodule

// File: rtl/sas_status_reg.sv
module sas_status_reg
  import sas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_evt,
  input  logic              close_partial,
  input  logic              power_loss,
  input  logic              wr_start,
  input  logic              copy_done,
  output logic [BYTE_W-1:0] status
);
  logic pf_q, auth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q   <= 1'b1;
      auth_q <= 1'b0;
    end else begin
      if (power_loss)     pf_q <= 1'b1;
      else if (close_evt) pf_q <= close_partial;
      if (wr_start)       auth_q <= 1'b0;
      else if (copy_done) auth_q <= 1'b1;
    end
  end

  assign status = pack_status(auth_q, pf_q);

  assert_power_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    power_loss |=> status[PF_POS]);
  assert_clean_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !close_partial && !power_loss) |=> !status[PF_POS]);
  assert_start_clears_auth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !status[AUTH_POS]);
  assert_pf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_evt && !power_loss) |=> $stable(status[PF_POS]));
endmodule

// File: rtl/scratch_addr_status.sv
module scratch_addr_status
  import sas_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [7:0]        addr_lo,
  input  logic [ADDR_W-9:0] addr_hi,
  input  logic              wr_start,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              wr_end,
  input  logic              bus_reset,
  input  logic              power_loss,
  input  logic              copy_done,
  output logic [ADDR_W-1:0] target_addr,
  output logic [BYTE_W-1:0] status_byte
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int CNT_W = $clog2(BYTE_W);

  logic active, close_evt, close_partial;

  sas_addr_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load),
    .lo_in(addr_lo), .hi_in(addr_hi), .addr(target_addr)
  );

  sas_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(wr_start),
    .bit_fire(bit_valid && active), .term(wr_end || bus_reset),
    .active(active), .close_evt(close_evt), .close_partial(close_partial)
  );

  sas_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .close_evt(close_evt),
    .close_partial(close_partial), .power_loss(power_loss),
    .wr_start(wr_start), .copy_done(copy_done), .status(status_byte)
  );

  assign bit_ready = active;
endmodule

// File: tb/test_scratch_addr_status.sv
module test_scratch_addr_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_load = 0, wr_start = 0, bit_valid = 0, wr_end = 0;
  logic bus_reset = 0, power_loss = 0, copy_done = 0;
  logic [7:0] addr_lo = 0, addr_hi = 0;
  logic bit_ready;
  logic [15:0] target_addr;
  logic [7:0] status_byte;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  scratch_addr_status i_scratch_addr_status (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .wr_start(wr_start), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .wr_end(wr_end), .bus_reset(bus_reset),
    .power_loss(power_loss), .copy_done(copy_done),
    .target_addr(target_addr), .status_byte(status_byte)
  );

  // [31:24] low byte, [23:16] high byte, [15:8] bit count, [0] close by bus reset
  localparam logic [31:0] VEC [6] = '{
    32'hA53C_0800, 32'hFFFF_0D00, 32'h0780_0001,
    32'h5A12_4001, 32'hC9E4_0300, 32'h1122_1101
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flags: {addr_load, wr_start, wr_end, bus_reset, power_loss, copy_done}
  task automatic step(input logic [5:0] f);
    {addr_load, wr_start, wr_end, bus_reset, power_loss, copy_done} = f;
    @(negedge clk);
    {addr_load, wr_start, wr_end, bus_reset, power_loss, copy_done} = '0;
    bit_valid = 0;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1;
      @(negedge clk);
    end
    bit_valid = 0;
  endtask

  function automatic logic [7:0] exp_stat(input logic auth, input logic pf);
    return 8'h5F | {auth, 7'b0} | {2'b0, pf, 5'b0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(target_addr == 16'h0, "R1 addr", target_addr, 0);
    chk(status_byte == 8'h7F, "R1 status", status_byte, 8'h7F);
    chk(bit_ready == 0, "R1 ready", bit_ready, 0);

    foreach (VEC[k]) begin
      logic [7:0] lo, hi, nb;
      logic use_rst, pf;
      lo = VEC[k][31:24]; hi = VEC[k][23:16]; nb = VEC[k][15:8]; use_rst = VEC[k][0];
      pf = (nb % 8) != 0;
      addr_lo = lo; addr_hi = hi;
      step(6'b100000);
      chk(target_addr == {hi, lo & 8'hF8}, "R2 addr", target_addr, {hi, lo & 8'hF8});
      step(6'b010000);
      chk(bit_ready == 1, "R4 ready open", bit_ready, 1);
      send_bits(int'(nb));
      step(use_rst ? 6'b000100 : 6'b001000);
      chk(status_byte == exp_stat(0, pf), use_rst ? "R7 close by bus reset" :
          (pf ? "R6 partial close" : "R5 clean close"), status_byte, exp_stat(0, pf));
      chk((status_byte & 8'h5F) == 8'h5F, "R3 fixed ones", status_byte, 8'h5F);
      chk(bit_ready == 0, "R4 ready closed", bit_ready, 0);
    end

    // R4: bits and strobes with no open write change nothing (pf is 1 from last vector)
    step(6'b010000); send_bits(16); step(6'b001000);
    chk(status_byte[5] == 0, "R5 setup", status_byte[5], 0);
    bit_valid = 1; @(negedge clk);
    chk(bit_ready == 0, "R4 idle ready", bit_ready, 0);
    send_bits(4); step(6'b001000); step(6'b000100);
    chk(status_byte == exp_stat(0, 0), "R4 idle ignored", status_byte, exp_stat(0, 0));

    // R10: eighth bit arrives together with the end strobe
    step(6'b010000); send_bits(7); bit_valid = 1; step(6'b001000);
    chk(status_byte[5] == 0, "R10 bit with close", status_byte[5], 0);
    step(6'b010000); send_bits(6); bit_valid = 1; step(6'b001000);
    chk(status_byte[5] == 1, "R10 seventh bit with close", status_byte[5], 1);

    // R8: power loss with a clean close, and alone
    step(6'b010000); send_bits(8); step(6'b001010);
    chk(status_byte[5] == 1, "R8 power loss wins", status_byte[5], 1);
    step(6'b010000); send_bits(8); step(6'b001000);
    step(6'b000010);
    chk(status_byte[5] == 1, "R8 power loss idle", status_byte[5], 1);

    // R11: restart mid-write
    step(6'b010000); send_bits(3); step(6'b010000); send_bits(8); step(6'b001000);
    chk(status_byte[5] == 0, "R11 restart count", status_byte[5], 0);

    // R9: authorization flag
    step(6'b000001);
    chk(status_byte == exp_stat(1, 0), "R9 copy sets auth", status_byte, exp_stat(1, 0));
    step(6'b010001);
    chk(status_byte[7] == 0, "R9 start wins over copy", status_byte[7], 0);
    step(6'b001000);

    // R1: reset mid-operation restores defaults
    addr_lo = 8'h77; addr_hi = 8'h66; step(6'b100000);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk(target_addr == 0 && status_byte == 8'h7F, "R1 re-reset",
        {target_addr, status_byte}, 24'h7F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule